// File: doc/BRIEF.md
# ROM Overlay Memory Decoder

This block decodes the memory cycles of an 8-bit bus slave that carries on-board static RAM and two ROM sockets. The RAM is two banks that together fill a 64K space. The upper address bit picks the bank. Each ROM socket has a window that the configuration places on any 256-byte page and sizes in whole pages. A cycle that lands in a window goes to that ROM, and the RAM underneath is left deselected for that cycle.

An optional qualifier compares the top eight bits of a 24-bit extended address with a configured page value, and the board responds only on a match. An optional wait generator holds `ready` low for the first few cycles of each memory strobe that hits a ROM window. RAM cycles are never stretched.

The decode is combinational from the address and strobe. The wait counter is the only state.

Top module: `rom_overlay_decoder`

## Requirements
- R1: When the board responds and no ROM window is hit, exactly one RAM select is driven. `ramCs[0]` is driven when address bit 15 is 0 and `ramCs[1]` when it is 1.
- R2: ROM window i covers page P = address[15:8] when P >= base_i and P < base_i + size_i. The base `romBase[8i+7:8i]` is in 256-byte pages. The size `romSize[9i+8:9i]` is in pages, and a size of 0 disables the window.
- R3: When both windows cover the address, only socket 0 (`romCs[0]`) is selected.
- R4: A read that hits a ROM window drives that ROM's select and no RAM select.
- R5: A write that hits a ROM window drives no ROM select, no RAM select and no `ramWe`, so the RAM underneath is unchanged.
- R6: `ramWe` is high only during a responding write that selects RAM.
- R7: With `overlayEn` low, no ROM select is driven, and every responding cycle selects RAM.
- R8: With `extEn` high, the board responds (`boardSel`, any select) only when `extAddr` equals `extPage`. With `extEn` low, `extAddr` is ignored.
- R9: With `waitEn` high and `waitCount` = N (0..7), a strobe that hits a ROM window holds `ready` low for exactly its first N cycles. `ready` is high from cycle N+1 on.
- R10: `ready` is low only during a responding cycle that hits a ROM window with waits enabled. RAM cycles, idle cycles and cycles with `waitEn` low keep `ready` high.
- R11: With `memReq` low, no select, `ramWe` or `boardSel` is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| memReq | input | 1 | Memory cycle strobe, held for the whole cycle |
| memWrite | input | 1 | 1 for a write cycle, 0 for a read cycle |
| addr | input | 16 | Address bus |
| extAddr | input | 8 | Extended address bits 23:16 |
| extEn | input | 1 | Enable the extended-page qualifier |
| extPage | input | 8 | Page that the extended bits must match |
| overlayEn | input | 1 | Enable both ROM windows |
| romBase | input | 16 | Start page of each window, 8 bits per socket |
| romSize | input | 18 | Size of each window in pages, 9 bits per socket |
| waitEn | input | 1 | Enable ROM wait states |
| waitCount | input | 3 | Number of ROM wait cycles |
| ramCs | output | 2 | RAM bank selects |
| romCs | output | 2 | ROM socket selects |
| ramWe | output | 1 | RAM write enable |
| ready | output | 1 | Low while the cycle is stretched |
| boardSel | output | 1 | Board responds to this cycle |

## Verification
Two things can happen in the same cycle: overlap priority and wait insertion. When both windows cover the same page while waits are enabled, the decode must pick socket 0 in the very cycle that `ready` drops. The bench provokes this by placing socket 1's window over the top of socket 0's window and holding a read strobe there for several cycles. A scoreboard compares the selects and `ready` cycle by cycle against an independent model.

It also provokes the write-ignore path. A write strobe is held in a ROM window with waits enabled. `ready` must still count down, while all chip selects stay off.

// File: rtl/rov_pkg.sv
package rov_pkg;
  // Strobes passed from the control to the datapath.
  typedef struct packed {
    logic cycleStart;  // first cycle of a memory strobe
    logic stall;       // hold ready low this cycle
  } ctrlStrobes_t;
endpackage

// File: rtl/rov_window.sv
module rov_window #(
  parameter int PAGE_W = 8
) (
  input  logic [PAGE_W-1:0] page,
  input  logic [PAGE_W-1:0] base,
  input  logic [PAGE_W:0]   size,
  input  logic              enable,
  output logic              hit
);
  logic [PAGE_W:0] pageExt;
  logic [PAGE_W:0] lowEdge;
  logic [PAGE_W:0] highEdge;

  always_comb begin
    pageExt  = {1'b0, page};
    lowEdge  = {1'b0, base};
    highEdge = lowEdge + size;
    hit      = enable && (size != '0) && (pageExt >= lowEdge) && (pageExt < highEdge);
  end
endmodule

// File: rtl/rov_datapath.sv
module rov_datapath
  import rov_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int EXT_W   = 8,
  parameter int NUM_ROM = 2,
  parameter int NUM_RAM = 2
) (
  input  logic                        memReq,
  input  logic                        memWrite,
  input  logic [ADDR_W-1:0]           addr,
  input  logic [EXT_W-1:0]            extAddr,
  input  logic                        extEn,
  input  logic [EXT_W-1:0]            extPage,
  input  logic                        overlayEn,
  input  logic [NUM_ROM*(ADDR_W-8)-1:0] romBase,
  input  logic [NUM_ROM*(ADDR_W-7)-1:0] romSize,
  input  ctrlStrobes_t                strobes,
  output logic                        romHitQual,
  output logic [NUM_RAM-1:0]          ramCs,
  output logic [NUM_ROM-1:0]          romCs,
  output logic                        ramWe,
  output logic                        ready,
  output logic                        boardSel
);
  localparam int PAGE_W   = ADDR_W - 8;
  localparam int SIZE_W   = PAGE_W + 1;
  localparam int RAM_BITS = $clog2(NUM_RAM);

  logic [PAGE_W-1:0]   page;
  logic [NUM_ROM-1:0]  winHit;
  logic [NUM_ROM-1:0]  winWinner;
  logic [RAM_BITS-1:0] bankIdx;
  logic                anyHit;
  logic                found;

  assign page    = addr[ADDR_W-1:8];
  assign bankIdx = addr[ADDR_W-1 -: RAM_BITS];

  for (genvar gi = 0; gi < NUM_ROM; gi++) begin : g_win
    rov_window #(.PAGE_W(PAGE_W)) u_win (
      .page  (page),
      .base  (romBase[gi*PAGE_W +: PAGE_W]),
      .size  (romSize[gi*SIZE_W +: SIZE_W]),
      .enable(overlayEn),
      .hit   (winHit[gi])
    );
  end

  // Lowest-numbered socket wins an overlap.
  always_comb begin
    winWinner = '0;
    found     = 1'b0;
    for (int i = 0; i < NUM_ROM; i++) begin
      if (winHit[i] && !found) begin
        winWinner[i] = 1'b1;
        found        = 1'b1;
      end
    end
  end

  always_comb begin
    boardSel   = memReq && (!extEn || (extAddr == extPage));
    anyHit     = |winHit;
    romHitQual = boardSel && anyHit;
    romCs      = (boardSel && !memWrite) ? winWinner : '0;
    ramCs      = '0;
    if (boardSel && !anyHit) ramCs[bankIdx] = 1'b1;
    ramWe      = memWrite && (ramCs != '0);
    ready      = !strobes.stall;
  end
endmodule

// File: rtl/rov_control.sv
module rov_control
  import rov_pkg::*;
#(
  parameter int WAIT_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              memReq,
  input  logic              romHitQual,
  input  logic              waitEn,
  input  logic [WAIT_W-1:0] waitCount,
  output ctrlStrobes_t      strobes
);
  logic              memReqQ;
  logic [WAIT_W-1:0] waitLeft;
  logic              startWait;

  always_comb begin
    strobes.cycleStart = memReq && !memReqQ;
    startWait          = strobes.cycleStart && romHitQual && waitEn && (waitCount != '0);
    strobes.stall      = memReq && (strobes.cycleStart ? startWait : (waitLeft != '0));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      memReqQ  <= 1'b0;
      waitLeft <= '0;
    end else begin
      memReqQ <= memReq;
      if (!memReq)                 waitLeft <= '0;
      else if (strobes.cycleStart) waitLeft <= startWait ? waitCount - 1'b1 : '0;
      else if (waitLeft != '0)     waitLeft <= waitLeft - 1'b1;
    end
  end
endmodule

// File: rtl/rom_overlay_decoder.sv
module rom_overlay_decoder
  import rov_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int EXT_W   = 8,
  parameter int NUM_ROM = 2,
  parameter int NUM_RAM = 2,
  parameter int WAIT_W  = 3
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          memReq,
  input  logic                          memWrite,
  input  logic [ADDR_W-1:0]             addr,
  input  logic [EXT_W-1:0]              extAddr,
  input  logic                          extEn,
  input  logic [EXT_W-1:0]              extPage,
  input  logic                          overlayEn,
  input  logic [NUM_ROM*(ADDR_W-8)-1:0] romBase,
  input  logic [NUM_ROM*(ADDR_W-7)-1:0] romSize,
  input  logic                          waitEn,
  input  logic [WAIT_W-1:0]             waitCount,
  output logic [NUM_RAM-1:0]            ramCs,
  output logic [NUM_ROM-1:0]            romCs,
  output logic                          ramWe,
  output logic                          ready,
  output logic                          boardSel
);
  ctrlStrobes_t strobes;
  logic         romHitQual;

  rov_control #(.WAIT_W(WAIT_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .memReq    (memReq),
    .romHitQual(romHitQual),
    .waitEn    (waitEn),
    .waitCount (waitCount),
    .strobes   (strobes)
  );

  rov_datapath #(
    .ADDR_W (ADDR_W),
    .EXT_W  (EXT_W),
    .NUM_ROM(NUM_ROM),
    .NUM_RAM(NUM_RAM)
  ) u_dp (
    .memReq    (memReq),
    .memWrite  (memWrite),
    .addr      (addr),
    .extAddr   (extAddr),
    .extEn     (extEn),
    .extPage   (extPage),
    .overlayEn (overlayEn),
    .romBase   (romBase),
    .romSize   (romSize),
    .strobes   (strobes),
    .romHitQual(romHitQual),
    .ramCs     (ramCs),
    .romCs     (romCs),
    .ramWe     (ramWe),
    .ready     (ready),
    .boardSel  (boardSel)
  );
endmodule

// File: rtl/rov_checker.sv
module rov_checker #(
  parameter int ADDR_W  = 16,
  parameter int EXT_W   = 8,
  parameter int NUM_ROM = 2,
  parameter int NUM_RAM = 2
) (
  input logic               clk,
  input logic               rstN,
  input logic               memReq,
  input logic               memWrite,
  input logic [EXT_W-1:0]   extAddr,
  input logic               extEn,
  input logic [EXT_W-1:0]   extPage,
  input logic               overlayEn,
  input logic               waitEn,
  input logic [NUM_RAM-1:0] ramCs,
  input logic [NUM_ROM-1:0] romCs,
  input logic               ramWe,
  input logic               ready,
  input logic               boardSel
);
  assert_one_select_R4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ramCs, romCs}));

  assert_rom_write_dropped_R5: assert property (@(posedge clk) disable iff (!rstN)
    memWrite |-> (romCs == '0));

  assert_we_needs_ram_R6: assert property (@(posedge clk) disable iff (!rstN)
    ramWe |-> (memWrite && (ramCs != '0)));

  assert_overlay_off_R7: assert property (@(posedge clk) disable iff (!rstN)
    !overlayEn |-> (romCs == '0));

  assert_ext_mismatch_R8: assert property (@(posedge clk) disable iff (!rstN)
    (extEn && (extAddr != extPage)) |-> (!boardSel && ramCs == '0 && romCs == '0));

  assert_no_wait_disabled_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!waitEn || !boardSel) |-> ready);

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rstN)
    !memReq |-> (!boardSel && ramCs == '0 && romCs == '0 && !ramWe && ready));
endmodule

bind rom_overlay_decoder rov_checker #(
  .ADDR_W (ADDR_W),
  .EXT_W  (EXT_W),
  .NUM_ROM(NUM_ROM),
  .NUM_RAM(NUM_RAM)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .memReq   (memReq),
  .memWrite (memWrite),
  .extAddr  (extAddr),
  .extEn    (extEn),
  .extPage  (extPage),
  .overlayEn(overlayEn),
  .waitEn   (waitEn),
  .ramCs    (ramCs),
  .romCs    (romCs),
  .ramWe    (ramWe),
  .ready    (ready),
  .boardSel (boardSel)
);

// File: tb/rom_overlay_decoder_tb.sv
module rom_overlay_decoder_tb;
  typedef struct {
    logic [1:0] ramCs;
    logic [1:0] romCs;
    logic       ramWe;
    logic       ready;
    logic       boardSel;
    string      tag;
  } expItem_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        memReq = 1'b0;
  logic        memWrite = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0]  extAddr = '0;
  logic        extEn = 1'b0;
  logic [7:0]  extPage = '0;
  logic        overlayEn = 1'b1;
  logic [7:0]  base0 = 8'hF0;
  logic [7:0]  base1 = 8'hE8;
  logic [8:0]  size0 = 9'd16;
  logic [8:0]  size1 = 9'd8;
  logic        waitEn = 1'b0;
  logic [2:0]  waitCount = '0;
  logic [1:0]  ramCs;
  logic [1:0]  romCs;
  logic        ramWe;
  logic        ready;
  logic        boardSel;

  int testsRun = 0;
  int testsFailed = 0;
  bit done = 0;
  expItem_t expQ[$];

  always #4 clk = ~clk;

  rom_overlay_decoder u_dut (
    .clk(clk), .rstN(rstN), .memReq(memReq), .memWrite(memWrite), .addr(addr),
    .extAddr(extAddr), .extEn(extEn), .extPage(extPage), .overlayEn(overlayEn),
    .romBase({base1, base0}), .romSize({size1, size0}), .waitEn(waitEn),
    .waitCount(waitCount), .ramCs(ramCs), .romCs(romCs), .ramWe(ramWe),
    .ready(ready), .boardSel(boardSel)
  );

  function automatic logic inWin(logic [7:0] pg, logic [7:0] b, logic [8:0] s);
    return overlayEn && (s != 0) && ({1'b0, pg} >= {1'b0, b}) && ({1'b0, pg} < ({1'b0, b} + s));
  endfunction

  // Driver: applies one bus cycle and queues its expected outputs.
  task automatic step(input logic req, input logic wr, input logic [15:0] a,
                      input logic [7:0] ext, input logic expReady, input string tag);
    expItem_t e;
    logic h0, h1, brd;
    @(negedge clk);
    memReq = req; memWrite = wr; addr = a; extAddr = ext;
    brd = req && (!extEn || ext == extPage);
    h0  = inWin(a[15:8], base0, size0);
    h1  = inWin(a[15:8], base1, size1);
    e.boardSel = brd;
    e.romCs = (brd && !wr) ? (h0 ? 2'b01 : (h1 ? 2'b10 : 2'b00)) : 2'b00;
    e.ramCs = (brd && !(h0 || h1)) ? (a[15] ? 2'b10 : 2'b01) : 2'b00;
    e.ramWe = wr && (e.ramCs != 0);
    e.ready = expReady;
    e.tag   = tag;
    expQ.push_back(e);
  endtask

  task automatic idle();
    step(1'b0, 1'b0, 16'h0000, 8'h00, 1'b1, "R11 idle");
  endtask

  // Monitor: samples mid-cycle and compares against the queue head.
  initial begin
    forever begin
      @(negedge clk);
      #3;
      if (expQ.size() > 0) begin
        expItem_t e;
        e = expQ.pop_front();
        testsRun++;
        if (ramCs !== e.ramCs || romCs !== e.romCs || ramWe !== e.ramWe ||
            ready !== e.ready || boardSel !== e.boardSel) begin
          testsFailed++;
          $display("FAIL %s: got ramCs=%b romCs=%b we=%b rdy=%b sel=%b exp ramCs=%b romCs=%b we=%b rdy=%b sel=%b",
                   e.tag, ramCs, romCs, ramWe, ready, boardSel,
                   e.ramCs, e.romCs, e.ramWe, e.ready, e.boardSel);
        end
      end
    end
  end

  initial begin
    #200000;
    if (!done) begin
      testsRun++; testsFailed++;
      $display("FAIL watchdog: got hang exp completion");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    idle();                                            // R11 reset state
    // R1 RAM banks
    step(1, 0, 16'h1234, 8'h00, 1, "R1 low bank read");
    idle();
    step(1, 1, 16'h9000, 8'h00, 1, "R1 R6 high bank write");
    idle();
    // R2 window edges, R4 overlay
    step(1, 0, 16'hF000, 8'h00, 1, "R2 R4 rom0 first byte");
    step(1, 0, 16'hFFFF, 8'h00, 1, "R2 rom0 last byte");
    step(1, 0, 16'hEFFF, 8'h00, 1, "R2 rom1 last byte");
    step(1, 0, 16'hE7FF, 8'h00, 1, "R2 below rom1 is RAM");
    idle();
    // R5 write into ROM ignored
    step(1, 1, 16'hF100, 8'h00, 1, "R5 write in rom0");
    idle();
    step(1, 1, 16'h0100, 8'h00, 1, "R6 low bank write");
    idle();
    // R2 size zero disables
    size1 = 9'd0;
    step(1, 0, 16'hE900, 8'h00, 1, "R2 size0 disabled window");
    idle();
    size1 = 9'd8;
    // R7 overlay disable
    overlayEn = 1'b0;
    step(1, 0, 16'hF800, 8'h00, 1, "R7 overlay off read");
    idle();
    overlayEn = 1'b1;
    // R8 extended qualifier
    extEn = 1'b1; extPage = 8'h05;
    step(1, 0, 16'h2000, 8'h04, 1, "R8 ext mismatch");
    idle();
    step(1, 0, 16'h2000, 8'h05, 1, "R8 ext match");
    idle();
    extEn = 1'b0;
    step(1, 0, 16'h2000, 8'h04, 1, "R8 ext ignored when off");
    idle();
    // R9 waits with overlap priority R3 at the same time
    base1 = 8'hF8; size1 = 9'd8;
    waitEn = 1'b1; waitCount = 3'd3;
    step(1, 0, 16'hF900, 8'h00, 0, "R3 R9 wait1");
    step(1, 0, 16'hF900, 8'h00, 0, "R3 R9 wait2");
    step(1, 0, 16'hF900, 8'h00, 0, "R3 R9 wait3");
    step(1, 0, 16'hF900, 8'h00, 1, "R3 R9 released");
    step(1, 0, 16'hF900, 8'h00, 1, "R9 stays ready");
    idle();
    // R9 max count with a write into ROM
    waitCount = 3'd7;
    for (int i = 0; i < 7; i++) step(1, 1, 16'hF000, 8'h00, 0, "R5 R9 write wait");
    step(1, 1, 16'hF000, 8'h00, 1, "R9 seven waits done");
    idle();
    // R10 RAM never waits
    step(1, 0, 16'h4000, 8'h00, 1, "R10 ram no wait");
    idle();
    // R9 zero count
    waitCount = 3'd0;
    step(1, 0, 16'hF000, 8'h00, 1, "R9 zero waits");
    idle();
    // R10 waits disabled
    waitEn = 1'b0; waitCount = 3'd4;
    step(1, 0, 16'hF000, 8'h00, 1, "R10 waits disabled");
    idle();
    // R9 one wait on rom1
    waitEn = 1'b1; waitCount = 3'd1; base1 = 8'hE8;
    step(1, 0, 16'hE800, 8'h00, 0, "R9 single wait rom1");
    step(1, 0, 16'hE800, 8'h00, 1, "R9 single wait done");
    idle();
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule